// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date for an interrupt-capable timekeeping subsystem. Seconds, minutes, hours, day of month, month and a two-digit year are held in packed BCD. The day of the week is a seven-bit ring with exactly one bit set, and it rotates once per day. Day-of-month rollover follows the length of the current month. February gets its extra day whenever the year value is a multiple of four, and that includes year 00.

A prescaler divides a sub-second tick stream, nominally 2048 Hz, down to one advance per second. A freeze input stops all counting and holds the prescaler at zero, so restarting it gives a full, clean second. Software loads any field through a shared data bus, with one write enable per field. Two registered strobes go to the interrupt logic: one marks every second advance, and one marks the seconds rolling from 59 to 00.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count 00h to 59h in BCD. Each wraps to 00h. A wrap of seconds advances minutes, and a wrap of minutes advances hours.
- R2: Hours count 00h to 23h in BCD. A wrap from 23h to 00h advances both the weekday and the day of month.
- R3: The weekday rotates 01h, 02h, 04h, 08h, 10h, 20h, 40h and back to 01h, one step per day. 01h is Sunday.
- R4: The day of month returns to 01h, and the month advances, after 31h in months 01h, 03h, 05h, 07h, 08h, 10h and 12h, and after 30h in months 04h, 06h, 09h and 11h.
- R5: In month 02h the day of month wraps after 28h, or after 29h when the year is a multiple of four. A year is a multiple of four when its tens digit is even and its units digit is 0, 4 or 8, or when its tens digit is odd and its units digit is 2 or 6.
- R6: Months count 01h to 12h and wrap to 01h. A month wrap advances the year, which counts 00h to 99h in BCD and wraps to 00h.
- R7: Bits above each field's width read as 0. The widths are: seconds 7, minutes 7, hours 6, weekday 7, day 6, month 5, year 8. Written data is cut to these widths.
- R8: While `stop` is 1, no field advances and the prescaler is held at zero. After `stop` returns to 0, the first advance comes on the PRESCALE-th sub-second tick.
- R9: A write to a field in the cycle of that field's advance takes priority over the increment. Carries out of that field still propagate, and they are computed from the value it had before the write.
- R10: `sec_stb` is high for one cycle after each second advance. `min_stb` is high in the same cycle when that advance wrapped the seconds from 59h.
- R11: After reset the fields read 00h seconds, 00h minutes, 00h hours, weekday 01h, day 01h, month 01h and year 00h. Both strobes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_in | input | 1 | Sub-second tick, one cycle per pulse |
| stop | input | 1 | Freezes counting and clears the prescaler |
| wr_en | input | 7 | Field write enables: bit 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year |
| wr_data | input | 8 | Data written to every enabled field |
| secs | output | 8 | Seconds, BCD |
| mins | output | 8 | Minutes, BCD |
| hours | output | 8 | Hours, BCD |
| wday | output | 8 | Weekday, one-hot in bits 6:0 |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Year, BCD |
| sec_stb | output | 1 | One-cycle strobe for each second advance |
| min_stb | output | 1 | One-cycle strobe when the seconds wrap from 59h |

## Verification
A software write to a field and the counting increment of that same field can fall in the same clock cycle. The bench provokes this by driving the last prescaler tick of a second in the very cycle that writes the seconds field, while the seconds stand at 59h. It then checks that the seconds show the written value and not 00h. It also checks that the minutes still advance and that both strobes fire, because the carry comes from the pre-write value.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int DAYS_PER_WEEK = 7;

  localparam int SEC_W   = 7;
  localparam int MIN_W   = 7;
  localparam int HOUR_W  = 6;
  localparam int DATE_W  = 6;
  localparam int MONTH_W = 5;
  localparam int YEAR_W  = 8;

  typedef enum int {
    FLD_SEC   = 0,
    FLD_MIN   = 1,
    FLD_HOUR  = 2,
    FLD_WDAY  = 3,
    FLD_DATE  = 4,
    FLD_MONTH = 5,
    FLD_YEAR  = 6
  } field_e;

  // Multiple of four on a BCD year: depends on tens parity and the units digit.
  function automatic logic is_leap(input logic tens_odd, input logic [3:0] units);
    if (!tens_odd) return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
    else           return (units == 4'd2) || (units == 4'd6);
  endfunction

  // Last valid day of month, in BCD.
  function automatic logic [7:0] month_end(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic sec_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  always_comb begin
    at_last  = (cnt_q == LAST);
    sec_tick = tick && !clr && at_last;
    cnt_d    = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field #(
  parameter int         W     = 7,
  parameter logic [7:0] FIRST = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic [7:0]   last,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] val,
  output logic         wrap
);
  logic [W-1:0] val_q, val_d, inc_v;
  logic [3:0]   lo;
  logic [W-5:0] hi;

  always_comb begin
    lo    = val_q[3:0];
    hi    = val_q[W-1:4];
    inc_v = (lo >= 4'd9) ? {hi + 1'b1, 4'h0} : {hi, lo + 4'h1};
    wrap  = inc && (8'(val_q) == last);
    val_d = val_q;
    if (wr)       val_d = wr_val;
    else if (inc) val_d = wrap ? FIRST[W-1:0] : inc_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= FIRST[W-1:0];
    else        val_q <= val_d;
  end

  assign val = val_q;
endmodule

// File: rtl/rtc_weekday_ring.sv
`timescale 1ns/1ps
module rtc_weekday_ring #(
  parameter int DAYS = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            wr,
  input  logic [DAYS-1:0] wr_val,
  output logic [DAYS-1:0] val
);
  localparam logic [DAYS-1:0] FIRST_DAY = DAYS'(1);

  logic [DAYS-1:0] ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (wr)       ring_d = wr_val;
    else if (inc) ring_d = {ring_q[DAYS-2:0], ring_q[DAYS-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= FIRST_DAY;
    else        ring_q <= ring_d;
  end

  assign val = ring_q;
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar #(
  parameter int PRESCALE = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       stop,
  input  logic [6:0] wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] secs,
  output logic [7:0] mins,
  output logic [7:0] hours,
  output logic [7:0] wday,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       sec_stb,
  output logic       min_stb
);
  import rtc_cal_pkg::*;

  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released through a short synchronizer.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[SYNC_STAGES-1];

  logic sec_tick;
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap, year_wrap;
  logic [SEC_W-1:0]         sec_v;
  logic [MIN_W-1:0]         min_v;
  logic [HOUR_W-1:0]        hour_v;
  logic [DAYS_PER_WEEK-1:0] wday_v;
  logic [DATE_W-1:0]        date_v;
  logic [MONTH_W-1:0]       month_v;
  logic [YEAR_W-1:0]        year_v;
  logic [7:0]               date_last;
  logic                     leap;

  rtc_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_q_n), .tick(tick_in), .clr(stop), .sec_tick(sec_tick)
  );

  rtc_bcd_field #(.W(SEC_W), .FIRST(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_q_n), .inc(sec_tick), .last(8'h59),
    .wr(wr_en[FLD_SEC]), .wr_val(wr_data[SEC_W-1:0]), .val(sec_v), .wrap(sec_wrap)
  );

  rtc_bcd_field #(.W(MIN_W), .FIRST(8'h00)) u_min (
    .clk(clk), .rst_n(rst_q_n), .inc(sec_wrap), .last(8'h59),
    .wr(wr_en[FLD_MIN]), .wr_val(wr_data[MIN_W-1:0]), .val(min_v), .wrap(min_wrap)
  );

  rtc_bcd_field #(.W(HOUR_W), .FIRST(8'h00)) u_hour (
    .clk(clk), .rst_n(rst_q_n), .inc(min_wrap), .last(8'h23),
    .wr(wr_en[FLD_HOUR]), .wr_val(wr_data[HOUR_W-1:0]), .val(hour_v), .wrap(hour_wrap)
  );

  rtc_weekday_ring #(.DAYS(DAYS_PER_WEEK)) u_wday (
    .clk(clk), .rst_n(rst_q_n), .inc(hour_wrap),
    .wr(wr_en[FLD_WDAY]), .wr_val(wr_data[DAYS_PER_WEEK-1:0]), .val(wday_v)
  );

  always_comb begin
    leap      = is_leap(year_v[4], year_v[3:0]);
    date_last = month_end(month_v, leap);
  end

  rtc_bcd_field #(.W(DATE_W), .FIRST(8'h01)) u_date (
    .clk(clk), .rst_n(rst_q_n), .inc(hour_wrap), .last(date_last),
    .wr(wr_en[FLD_DATE]), .wr_val(wr_data[DATE_W-1:0]), .val(date_v), .wrap(date_wrap)
  );

  rtc_bcd_field #(.W(MONTH_W), .FIRST(8'h01)) u_month (
    .clk(clk), .rst_n(rst_q_n), .inc(date_wrap), .last(8'h12),
    .wr(wr_en[FLD_MONTH]), .wr_val(wr_data[MONTH_W-1:0]), .val(month_v), .wrap(month_wrap)
  );

  rtc_bcd_field #(.W(YEAR_W), .FIRST(8'h00)) u_year (
    .clk(clk), .rst_n(rst_q_n), .inc(month_wrap), .last(8'h99),
    .wr(wr_en[FLD_YEAR]), .wr_val(wr_data[YEAR_W-1:0]), .val(year_v), .wrap(year_wrap)
  );

  // Strobes line up with the cycle the updated fields become visible.
  logic sec_stb_q, min_stb_q;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sec_stb_q <= 1'b0;
      min_stb_q <= 1'b0;
    end else begin
      sec_stb_q <= sec_tick;
      min_stb_q <= sec_wrap;
    end
  end

  logic unused_year_wrap;
  assign unused_year_wrap = year_wrap;

  assign secs    = 8'(sec_v);
  assign mins    = 8'(min_v);
  assign hours   = 8'(hour_v);
  assign wday    = 8'(wday_v);
  assign date    = 8'(date_v);
  assign month   = 8'(month_v);
  assign year    = year_v;
  assign sec_stb = sec_stb_q;
  assign min_stb = min_stb_q;
endmodule

// File: rtl/rtc_calendar_checker.sv
`timescale 1ns/1ps
module rtc_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stop,
  input logic [6:0] wr_en,
  input logic [7:0] secs,
  input logic [7:0] mins,
  input logic [7:0] hours,
  input logic [7:0] wday,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic       sec_stb,
  input logic       min_stb
);
  // R1: an unwritten advance from 59h lands on 00h and flags the wrap
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && $past(secs) == 8'h59 && !$past(wr_en[0])) |-> (secs == 8'h00 && min_stb));

  // R10: a minute strobe never appears without a second strobe
  p_min_with_sec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    min_stb |-> sec_stb);

  // R3: any unwritten change of the weekday is a one-step rotation
  p_wday_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en[3]) && wday != $past(wday))
      |-> (wday[6:0] == {$past(wday[5:0]), $past(wday[6])}));

  // R4: a month advance without writes restarts the day at 01h
  p_month_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en[5]) && !$past(wr_en[4]) && month != $past(month)) |-> (date == 8'h01));

  // R8: frozen and unwritten means every field holds
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop) && $past(wr_en) == 7'd0)
      |-> ($stable(secs) && $stable(mins) && $stable(hours) && $stable(wday)
           && $stable(date) && $stable(month) && $stable(year) && !sec_stb));
endmodule

bind rtc_calendar rtc_calendar_checker u_rtc_calendar_checker (
  .clk(clk), .rst_n(rst_n), .stop(stop), .wr_en(wr_en),
  .secs(secs), .mins(mins), .hours(hours), .wday(wday), .date(date),
  .month(month), .year(year), .sec_stb(sec_stb), .min_stb(min_stb)
);

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  localparam int PRE = 4;
  localparam int I_SEC = 0, I_MIN = 1, I_HOUR = 2, I_WDAY = 3, I_DATE = 4, I_MON = 5, I_YEAR = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_in;
  logic       stop;
  logic [6:0] wr_en;
  logic [7:0] wr_data;
  logic [7:0] secs, mins, hours, wday, date, month, year;
  logic       sec_stb, min_stb;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rtc_calendar #(.PRESCALE(PRE)) u_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .stop(stop), .wr_en(wr_en),
    .wr_data(wr_data), .secs(secs), .mins(mins), .hours(hours), .wday(wday),
    .date(date), .month(month), .year(year), .sec_stb(sec_stb), .min_stb(min_stb)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
  endtask

  task automatic one_second();
    repeat (PRE) pulse_tick();
  endtask

  task automatic put(input int idx, input logic [7:0] d);
    @(negedge clk); wr_en = 7'(1 << idx); wr_data = d;
    @(negedge clk); wr_en = '0;
  endtask

  task automatic set_all(input logic [7:0] y, mo, d, w, h, mi, s);
    put(I_YEAR, y); put(I_MON, mo); put(I_DATE, d); put(I_WDAY, w);
    put(I_HOUR, h); put(I_MIN, mi); put(I_SEC, s);
  endtask

  task automatic t_reset();
    chk("R11", "sec", secs, 8'h00);   chk("R11", "min", mins, 8'h00);
    chk("R11", "hour", hours, 8'h00); chk("R11", "wday", wday, 8'h01);
    chk("R11", "date", date, 8'h01);  chk("R11", "month", month, 8'h01);
    chk("R11", "year", year, 8'h00);
    chk("R11", "strobes", {6'd0, sec_stb, min_stb}, 8'h00);
  endtask

  task automatic t_seconds();
    set_all(8'h20, 8'h05, 8'h10, 8'h04, 8'h08, 8'h09, 8'h58);
    one_second();
    chk("R1", "sec 58->59", secs, 8'h59);
    chk("R10", "sec_stb", {7'd0, sec_stb}, 8'h01);
    chk("R10", "min_stb quiet", {7'd0, min_stb}, 8'h00);
    @(negedge clk);
    chk("R10", "sec_stb one cycle", {7'd0, sec_stb}, 8'h00);
    one_second();
    chk("R1", "sec wrap", secs, 8'h00);
    chk("R1", "min carry BCD 09->10", mins, 8'h10);
    chk("R10", "min_stb on wrap", {7'd0, min_stb}, 8'h01);
    put(I_MIN, 8'h59); put(I_SEC, 8'h59);
    one_second();
    chk("R1", "min wrap", mins, 8'h00);
    chk("R1", "hour carry", hours, 8'h09);
  endtask

  task automatic t_day_roll();
    set_all(8'h10, 8'h03, 8'h15, 8'h40, 8'h23, 8'h59, 8'h59);
    one_second();
    chk("R2", "hour wrap", hours, 8'h00);
    chk("R2", "date advance", date, 8'h16);
    chk("R3", "wday 40->01", wday, 8'h01);
  endtask

  task automatic t_week();
    logic [7:0] exp_w;
    exp_w = 8'h01;
    put(I_WDAY, 8'h01);
    for (int i = 0; i < 7; i++) begin
      put(I_HOUR, 8'h23); put(I_MIN, 8'h59); put(I_SEC, 8'h59);
      one_second();
      exp_w = (exp_w == 8'h40) ? 8'h01 : (exp_w << 1);
      chk("R3", "wday rotate", wday, exp_w);
    end
  endtask

  task automatic end_of_day(input logic [7:0] y, mo, d, input logic [7:0] ed, emo, ey, input string req);
    set_all(y, mo, d, 8'h01, 8'h23, 8'h59, 8'h59);
    one_second();
    chk(req, "date", date, ed);
    chk(req, "month", month, emo);
    chk(req, "year", year, ey);
  endtask

  task automatic t_months();
    end_of_day(8'h21, 8'h01, 8'h31, 8'h01, 8'h02, 8'h21, "R4");
    end_of_day(8'h21, 8'h04, 8'h30, 8'h01, 8'h05, 8'h21, "R4");
    end_of_day(8'h21, 8'h01, 8'h30, 8'h31, 8'h01, 8'h21, "R4");
    end_of_day(8'h21, 8'h11, 8'h30, 8'h01, 8'h12, 8'h21, "R4");
  endtask

  task automatic t_feb();
    end_of_day(8'h23, 8'h02, 8'h28, 8'h01, 8'h03, 8'h23, "R5");
    end_of_day(8'h24, 8'h02, 8'h28, 8'h29, 8'h02, 8'h24, "R5");
    end_of_day(8'h00, 8'h02, 8'h28, 8'h29, 8'h02, 8'h00, "R5");
    end_of_day(8'h12, 8'h02, 8'h28, 8'h29, 8'h02, 8'h12, "R5");
    end_of_day(8'h10, 8'h02, 8'h28, 8'h01, 8'h03, 8'h10, "R5");
    end_of_day(8'h96, 8'h02, 8'h29, 8'h01, 8'h03, 8'h96, "R5");
  endtask

  task automatic t_year();
    end_of_day(8'h99, 8'h12, 8'h31, 8'h01, 8'h01, 8'h00, "R6");
    end_of_day(8'h41, 8'h12, 8'h31, 8'h01, 8'h01, 8'h42, "R6");
    end_of_day(8'h09, 8'h12, 8'h31, 8'h01, 8'h01, 8'h10, "R6");
  endtask

  task automatic t_mask();
    put(I_SEC, 8'hFF);  chk("R7", "sec width", secs, 8'h7F);
    put(I_HOUR, 8'hFF); chk("R7", "hour width", hours, 8'h3F);
    put(I_WDAY, 8'hFF); chk("R7", "wday width", wday, 8'h7F);
    put(I_DATE, 8'hFF); chk("R7", "date width", date, 8'h3F);
    put(I_MON, 8'hFF);  chk("R7", "month width", month, 8'h1F);
    set_all(8'h30, 8'h06, 8'h10, 8'h02, 8'h10, 8'h20, 8'h30);
  endtask

  task automatic t_stop();
    put(I_SEC, 8'h30);
    @(negedge clk); stop = 1'b1;
    repeat (3 * PRE) pulse_tick();
    chk("R8", "frozen sec", secs, 8'h30);
    chk("R8", "no strobe", {7'd0, sec_stb}, 8'h00);
    @(negedge clk); stop = 1'b0;
    repeat (PRE - 2) pulse_tick();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (PRE - 1) pulse_tick();
    chk("R8", "prescaler cleared", secs, 8'h30);
    pulse_tick();
    chk("R8", "first advance after release", secs, 8'h31);
  endtask

  task automatic t_write_clash();
    put(I_MIN, 8'h10); put(I_SEC, 8'h59);
    repeat (PRE - 1) pulse_tick();
    @(negedge clk); tick_in = 1'b1; wr_en = 7'(1 << I_SEC); wr_data = 8'h30;
    @(negedge clk); tick_in = 1'b0; wr_en = '0;
    chk("R9", "write wins", secs, 8'h30);
    chk("R9", "carry kept", mins, 8'h11);
    chk("R10", "sec_stb at clash", {7'd0, sec_stb}, 8'h01);
    chk("R10", "min_stb at clash", {7'd0, min_stb}, 8'h01);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_in = 1'b0; stop = 1'b0; wr_en = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_seconds();
    t_day_roll();
    t_week();
    t_months();
    t_feb();
    t_year();
    t_mask();
    t_stop();
    t_write_clash();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule